// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block sits at the home node of a 16-cluster shared-memory machine. It keeps one directory entry for each memory line it owns. The coherence protocol is invalidation-based with ownership. The block takes one coherence request at a time from an incoming request channel. It reads the line's entry and checks its parity. It then decides what the line needs, writes the updated entry back, and emits messages on two independent output channels. The reply channel carries data grants and negative acknowledgements. The request channel carries forwarded requests and invalidations.

The home never gathers dirty data itself. When a line is held modified by a remote cluster, a read or a read-exclusive is forwarded to that owner, and the line is marked as having a forward in flight. The owner answers the requester directly. It then tells the home the outcome: a sharing write-back after a read, or an ownership update after a read-exclusive. That message clears the in-flight mark. Any read or read-exclusive that reaches the line while the mark is set is refused with a NAK and must be retried. Each entry holds an in-flight bit, a modified bit and a presence vector, and is stored with an even parity bit. In the modified state the presence vector names the single owner.

Top module: `hdir_ctrl`

## Requirements
- R1: After reset every line is uncached-remote and no forward is in flight. `req_ready_o` is 1, both output valids are 0 and `par_err_o` is 0.
- R2: A read (request type 0) to a line with no owner and no forward in flight returns a reply of type 0 (data) to the requester with count 0. The requester is added to the line's sharers.
- R3: A read to an owned line emits one forward of type 0 to the owner, carrying the requester in `fwd_req_o`, and sends no reply. A later sharing write-back (type 2, source = owner, aux = reader) leaves exactly those two clusters as sharers.
- R4: A read-exclusive (type 1) to a line with no owner sends one invalidation (forward type 2) to every sharer other than the requester, in ascending cluster order. It then sends a reply of type 1 whose count equals the number of invalidations (0 to 15). The requester becomes the sole owner.
- R5: A read-exclusive to an owned line emits a forward of type 1 to the owner, carrying the requester. A later ownership update (type 3, aux = new owner) makes the aux cluster the owner.
- R6: A dirty write-back (type 4) returns the line to uncached-remote with no sharers.
- R7: While a forward for a line is in flight, a read or read-exclusive to that line gets a reply of type 2 (NAK) and leaves the entry unchanged.
- R8: An entry whose parity fails on read sets `par_err_o`. The flag then stays set until reset, and `err_line_o` holds the first failing line. The request is answered with a NAK, and the entry is rewritten as uncached-remote.
- R9: `req_ready_o` stays 0 from the acceptance of a request until all of its messages have been handed off. While an output valid is high and its ready is low, that channel's valid and payload hold steady.
- R10: Sharing write-backs, ownership updates and dirty write-backs produce no outgoing message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Incoming request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_type_i | input | 3 | 0 read, 1 read-exclusive, 2 sharing write-back, 3 ownership update, 4 dirty write-back |
| req_src_i | input | CW | Sending cluster |
| req_aux_i | input | CW | Cluster named by an owner's message (reader or new owner) |
| req_line_i | input | LW | Line index |
| rpy_valid_o | output | 1 | Reply valid |
| rpy_ready_i | input | 1 | Reply accepted |
| rpy_type_o | output | 2 | 0 data, 1 exclusive data, 2 NAK |
| rpy_dst_o | output | CW | Reply destination (the requester) |
| rpy_line_o | output | LW | Line index of the reply |
| rpy_cnt_o | output | CW | Invalidations sent (exclusive data), else 0 |
| fwd_valid_o | output | 1 | Outgoing request valid |
| fwd_ready_i | input | 1 | Outgoing request accepted |
| fwd_type_o | output | 2 | 0 forwarded read, 1 forwarded read-exclusive, 2 invalidate |
| fwd_dst_o | output | CW | Target cluster |
| fwd_req_o | output | CW | Original requester |
| fwd_line_o | output | LW | Line index |
| par_err_o | output | 1 | Sticky parity error flag |
| err_line_o | output | LW | Line of the first parity error |

## Verification
The bench uses the full 16 clusters, so a single read-exclusive can fan out the largest invalidation burst, with 15 targets. It shrinks the directory to 8 lines. With so few lines, random traffic keeps hitting the same lines, and requests run into forwards that are still in flight, which yields NAKs and write-back races. Random backpressure on both output channels exercises the hold rules during invalidation bursts.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  typedef enum logic [2:0] {
    REQ_RD  = 3'd0,
    REQ_RDX = 3'd1,
    REQ_SWB = 3'd2,
    REQ_OWN = 3'd3,
    REQ_DWB = 3'd4
  } req_e;

  typedef enum logic [1:0] {
    RPY_DATA    = 2'd0,
    RPY_DATA_EX = 2'd1,
    RPY_NAK     = 2'd2
  } rpy_e;

  typedef enum logic [1:0] {
    FWD_RD  = 2'd0,
    FWD_RDX = 2'd1,
    FWD_INV = 2'd2
  } fwd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK,
    S_INV,
    S_RPY,
    S_FWD
  } st_e;
endpackage

// File: rtl/hdir_pick.sv
module hdir_pick #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/hdir_mem.sv
module hdir_mem #(
  parameter int N_CL    = 16,
  parameter int N_LINES = 64,
  localparam int LW = $clog2(N_LINES),
  localparam int BW = N_CL + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] rd_line_i,
  output logic [BW-1:0] rd_bits_o,
  output logic          rd_err_o,
  input  logic          wr_en_i,
  input  logic [LW-1:0] wr_line_i,
  input  logic [BW-1:0] wr_bits_i
);
  // entry: {parity, busy, dirty, presence}
  logic [BW:0] mem_q [N_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LINES; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_line_i] <= {^wr_bits_i, wr_bits_i};
    end
  end

  assign rd_bits_o = mem_q[rd_line_i][BW-1:0];
  assign rd_err_o  = ^mem_q[rd_line_i];

  a_r8_wr_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !(^mem_q[$past(wr_line_i)]));
endmodule

// File: rtl/hdir_ctrl.sv
module hdir_ctrl
  import hdir_pkg::*;
#(
  parameter int N_CL    = 16,
  parameter int N_LINES = 64,
  localparam int CW = $clog2(N_CL),
  localparam int LW = $clog2(N_LINES),
  localparam int BW = N_CL + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [2:0]    req_type_i,
  input  logic [CW-1:0] req_src_i,
  input  logic [CW-1:0] req_aux_i,
  input  logic [LW-1:0] req_line_i,
  output logic          rpy_valid_o,
  input  logic          rpy_ready_i,
  output logic [1:0]    rpy_type_o,
  output logic [CW-1:0] rpy_dst_o,
  output logic [LW-1:0] rpy_line_o,
  output logic [CW-1:0] rpy_cnt_o,
  output logic          fwd_valid_o,
  input  logic          fwd_ready_i,
  output logic [1:0]    fwd_type_o,
  output logic [CW-1:0] fwd_dst_o,
  output logic [CW-1:0] fwd_req_o,
  output logic [LW-1:0] fwd_line_o,
  output logic          par_err_o,
  output logic [LW-1:0] err_line_o
);
  st_e            st_q, nxt_st;
  req_e           r_type_q;
  logic [CW-1:0]  r_src_q, r_aux_q, own_q, cnt_q, nxt_cnt;
  logic [LW-1:0]  r_line_q, err_line_q;
  logic           e_busy_q, e_dirty_q, e_err_q, err_q;
  logic [N_CL-1:0] e_pres_q, inv_q, nxt_inv;
  rpy_e           rpy_type_q, nxt_rpy;
  fwd_e           fwd_type_q, nxt_fwd;

  logic [BW-1:0]  rd_bits, nxt_bits;
  logic           rd_err;
  logic [CW-1:0]  own_idx, inv_idx;
  logic           own_any, inv_any;
  logic [N_CL-1:0] inv_bit;

  hdir_mem #(.N_CL(N_CL), .N_LINES(N_LINES)) u_mem (
    .clk_i, .rst_ni,
    .rd_line_i (req_line_i),
    .rd_bits_o (rd_bits),
    .rd_err_o  (rd_err),
    .wr_en_i   (st_q == S_CHK),
    .wr_line_i (r_line_q),
    .wr_bits_i (nxt_bits)
  );

  hdir_pick #(.N(N_CL)) u_own (.vec_i(e_pres_q), .idx_o(own_idx), .any_o(own_any));
  hdir_pick #(.N(N_CL)) u_inv (.vec_i(inv_q),    .idx_o(inv_idx), .any_o(inv_any));

  assign inv_bit = N_CL'(1) << inv_idx;

  function automatic logic [CW-1:0] pop(input logic [N_CL-1:0] v);
    logic [CW:0] c;
    c = '0;
    for (int i = 0; i < N_CL; i++) c = c + (CW+1)'(v[i]);
    return c[CW-1:0];
  endfunction

  // decision for the latched request and entry
  always_comb begin
    logic [N_CL-1:0] src_oh, aux_oh, others;
    src_oh   = N_CL'(1) << r_src_q;
    aux_oh   = N_CL'(1) << r_aux_q;
    others   = e_pres_q & ~src_oh;
    nxt_bits = {e_busy_q, e_dirty_q, e_pres_q};
    nxt_st   = S_IDLE;
    nxt_rpy  = RPY_NAK;
    nxt_fwd  = FWD_RD;
    nxt_inv  = '0;
    nxt_cnt  = '0;
    if (e_err_q) begin
      nxt_bits = '0;
      nxt_st   = S_RPY;
    end else begin
      unique case (r_type_q)
        REQ_RD, REQ_RDX: begin
          if (e_busy_q) begin
            nxt_st = S_RPY;
          end else if (e_dirty_q) begin
            nxt_bits[BW-1] = 1'b1;
            nxt_fwd = (r_type_q == REQ_RD) ? FWD_RD : FWD_RDX;
            nxt_st  = S_FWD;
          end else if (r_type_q == REQ_RD) begin
            nxt_bits = {2'b00, e_pres_q | src_oh};
            nxt_rpy  = RPY_DATA;
            nxt_st   = S_RPY;
          end else begin
            nxt_bits = {2'b01, src_oh};
            nxt_rpy  = RPY_DATA_EX;
            nxt_inv  = others;
            nxt_cnt  = pop(others);
            nxt_st   = (others != '0) ? S_INV : S_RPY;
          end
        end
        REQ_SWB: nxt_bits = {2'b00, src_oh | aux_oh};
        REQ_OWN: nxt_bits = {2'b01, aux_oh};
        REQ_DWB: nxt_bits = '0;
        default: nxt_bits = {e_busy_q, e_dirty_q, e_pres_q};
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;      r_type_q <= REQ_RD;
      r_src_q <= '0;       r_aux_q <= '0;      r_line_q <= '0;
      e_busy_q <= 1'b0;    e_dirty_q <= 1'b0;  e_pres_q <= '0;  e_err_q <= 1'b0;
      own_q <= '0;         cnt_q <= '0;        inv_q <= '0;
      rpy_type_q <= RPY_DATA; fwd_type_q <= FWD_RD;
      err_q <= 1'b0;       err_line_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          r_type_q <= req_e'(req_type_i);
          r_src_q  <= req_src_i;
          r_aux_q  <= req_aux_i;
          r_line_q <= req_line_i;
          {e_busy_q, e_dirty_q, e_pres_q} <= rd_bits;
          e_err_q  <= rd_err;
          st_q     <= S_CHK;
        end
        S_CHK: begin
          st_q       <= nxt_st;
          rpy_type_q <= nxt_rpy;
          fwd_type_q <= nxt_fwd;
          own_q      <= own_idx;
          inv_q      <= nxt_inv;
          cnt_q      <= nxt_cnt;
          if (e_err_q && !err_q) begin
            err_q      <= 1'b1;
            err_line_q <= r_line_q;
          end
        end
        S_INV: if (fwd_ready_i) begin
          inv_q <= inv_q & ~inv_bit;
          if ((inv_q & ~inv_bit) == '0) st_q <= S_RPY;
        end
        S_RPY: if (rpy_ready_i) st_q <= S_IDLE;
        S_FWD: if (fwd_ready_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign rpy_valid_o = (st_q == S_RPY);
  assign rpy_type_o  = rpy_type_q;
  assign rpy_dst_o   = r_src_q;
  assign rpy_line_o  = r_line_q;
  assign rpy_cnt_o   = cnt_q;
  assign fwd_valid_o = (st_q == S_INV) || (st_q == S_FWD);
  assign fwd_type_o  = (st_q == S_INV) ? FWD_INV : fwd_type_q;
  assign fwd_dst_o   = (st_q == S_INV) ? inv_idx : own_q;
  assign fwd_req_o   = r_src_q;
  assign fwd_line_o  = r_line_q;
  assign par_err_o   = err_q;
  assign err_line_o  = err_line_q;

  a_r9_rpy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpy_valid_o && !rpy_ready_i |=> rpy_valid_o &&
      $stable({rpy_type_o, rpy_dst_o, rpy_line_o, rpy_cnt_o}));
  a_r9_fwd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o && !fwd_ready_i |=> fwd_valid_o &&
      $stable({fwd_type_o, fwd_dst_o, fwd_req_o, fwd_line_o}));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |=> par_err_o && $stable(err_line_o));
  a_r4_inv_not_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o && fwd_type_o == FWD_INV |-> fwd_dst_o != fwd_req_o && inv_any);
  a_r10_wb_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_CHK && !e_err_q && r_type_q inside {REQ_SWB, REQ_OWN, REQ_DWB}
      |=> req_ready_o);
  a_r3_fwd_has_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_CHK && nxt_st == S_FWD |-> own_any && $countones(e_pres_q) == 1);
endmodule

// File: tb/hdir_ctrl_test.sv
`timescale 1ns/1ps
module hdir_ctrl_test;
  localparam int N_CL = 16, N_LINES = 8, CW = 4, LW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [2:0]    req_type = '0;
  logic [CW-1:0] req_src = '0, req_aux = '0;
  logic [LW-1:0] req_line = '0;
  logic rpy_valid, rpy_ready = 1'b0, fwd_valid, fwd_ready = 1'b0;
  logic [1:0] rpy_type, fwd_type;
  logic [CW-1:0] rpy_dst, rpy_cnt, fwd_dst, fwd_req;
  logic [LW-1:0] rpy_line, fwd_line, err_line;
  logic par_err;

  hdir_ctrl #(.N_CL(N_CL), .N_LINES(N_LINES)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_src_i(req_src), .req_aux_i(req_aux), .req_line_i(req_line),
    .rpy_valid_o(rpy_valid), .rpy_ready_i(rpy_ready), .rpy_type_o(rpy_type),
    .rpy_dst_o(rpy_dst), .rpy_line_o(rpy_line), .rpy_cnt_o(rpy_cnt),
    .fwd_valid_o(fwd_valid), .fwd_ready_i(fwd_ready), .fwd_type_o(fwd_type),
    .fwd_dst_o(fwd_dst), .fwd_req_o(fwd_req), .fwd_line_o(fwd_line),
    .par_err_o(par_err), .err_line_o(err_line)
  );

  int n_vec = 0, n_err = 0;

  // reference model
  logic [N_CL-1:0] m_pres [N_LINES];
  logic m_dirty [N_LINES];
  logic m_busy  [N_LINES];
  int   m_preq  [N_LINES];
  int   m_pk    [N_LINES];
  int   exp_m [0:31];
  int   got_m [0:31];
  int   exp_n, got_n;

  function automatic int mk(int is_rpy, int typ, int dst, int extra, int line);
    return (is_rpy << 24) | (typ << 20) | (dst << 12) | (extra << 8) | line;
  endfunction

  function automatic int owner_of(logic [N_CL-1:0] v);
    for (int i = 0; i < N_CL; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict(int t, int s, int a, int l);
    logic [N_CL-1:0] sb;
    int n;
    sb = N_CL'(1) << s;
    exp_n = 0;
    case (t)
      0, 1: begin
        if (m_busy[l]) begin
          exp_m[exp_n++] = mk(1, 2, s, 0, l);
        end else if (m_dirty[l]) begin
          exp_m[exp_n++] = mk(0, t, owner_of(m_pres[l]), s, l);
          m_busy[l] = 1'b1; m_preq[l] = s; m_pk[l] = t;
        end else if (t == 0) begin
          m_pres[l] = m_pres[l] | sb;
          exp_m[exp_n++] = mk(1, 0, s, 0, l);
        end else begin
          n = 0;
          for (int c = 0; c < N_CL; c++)
            if (m_pres[l][c] && c != s) begin
              exp_m[exp_n++] = mk(0, 2, c, s, l);
              n++;
            end
          exp_m[exp_n++] = mk(1, 1, s, n, l);
          m_pres[l] = sb; m_dirty[l] = 1'b1;
        end
      end
      2: begin m_pres[l] = sb | (N_CL'(1) << a); m_dirty[l] = 1'b0; m_busy[l] = 1'b0; end
      3: begin m_pres[l] = N_CL'(1) << a; m_dirty[l] = 1'b1; m_busy[l] = 1'b0; end
      default: begin m_pres[l] = '0; m_dirty[l] = 1'b0; m_busy[l] = 1'b0; end
    endcase
  endtask

  // issue one request, collect its messages, compare to prediction
  task automatic run(int t, int s, int a, int l, string req);
    bit rh, fh, first;
    int rp, fp, cur;
    got_n = 0; rh = 0; fh = 0; first = 1; rp = 0; fp = 0;
    @(negedge clk);
    req_valid = 1'b1; req_type = 3'(t); req_src = CW'(s); req_aux = CW'(a); req_line = LW'(l);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (cyc > 0) @(negedge clk);
      rpy_ready = ($urandom % 4) != 0;
      fwd_ready = ($urandom % 4) != 0;
      #1;
      if (first) begin
        check(!req_ready, "R9 busy", int'(req_ready), 0);
        first = 0;
      end
      if (req_ready) break;
      cur = mk(1, int'(rpy_type), int'(rpy_dst), int'(rpy_cnt), int'(rpy_line));
      if (rh) check(rpy_valid && cur == rp, "R9 rpy hold", cur, rp);
      if (rpy_valid && rpy_ready && got_n < 32) got_m[got_n++] = cur;
      rh = rpy_valid && !rpy_ready; rp = cur;
      cur = mk(0, int'(fwd_type), int'(fwd_dst), int'(fwd_req), int'(fwd_line));
      if (fh) check(fwd_valid && cur == fp, "R9 fwd hold", cur, fp);
      if (fwd_valid && fwd_ready && got_n < 32) got_m[got_n++] = cur;
      fh = fwd_valid && !fwd_ready; fp = cur;
    end
    check(got_n == exp_n, req, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got_m[i] == exp_m[i], req, got_m[i], exp_m[i]);
  endtask

  task automatic go(int t, int s, int a, int l, string req);
    predict(t, s, a, l);
    run(t, s, a, l, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int l, s, t, o;
    void'($urandom(32'd1234));
    for (int i = 0; i < N_LINES; i++) begin
      m_pres[i] = '0; m_dirty[i] = 0; m_busy[i] = 0; m_preq[i] = 0; m_pk[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_ready && !rpy_valid && !fwd_valid && !par_err, "R1 reset",
          {req_ready, rpy_valid, fwd_valid, par_err}, 4'b1000);

    go(0, 3, 0, 0, "R1 R2 read uncached");
    go(0, 5, 0, 0, "R2 read shared");
    go(1, 5, 0, 0, "R4 rdx one other sharer");
    go(0, 7, 0, 0, "R3 read forwarded to owner");
    go(0, 2, 0, 0, "R7 nak read");
    go(1, 9, 0, 0, "R7 nak rdx");
    go(2, 5, 7, 0, "R10 R3 sharing writeback silent");
    go(1, 1, 0, 0, "R3 R4 two sharers invalidated in order");
    go(1, 4, 0, 0, "R5 rdx forwarded to owner");
    go(3, 1, 4, 0, "R10 R5 ownership update silent");
    go(0, 6, 0, 0, "R5 read forwarded to new owner");
    go(2, 4, 6, 0, "R10 sharing writeback");
    go(1, 2, 0, 1, "R4 rdx no sharers count 0");
    go(4, 2, 0, 1, "R10 R6 dirty writeback silent");
    go(1, 8, 0, 1, "R6 line uncached after writeback");
    for (int c = 0; c < N_CL; c++) go(0, c, 0, 2, "R2 all clusters share");
    go(1, 0, 0, 2, "R4 fan-out of 15");

    // corrupt a stored entry bit to break parity
    @(negedge clk);
    uut.u_mem.mem_q[3][4] <= ~uut.u_mem.mem_q[3][4];
    @(negedge clk);
    m_pres[3] = '0; m_dirty[3] = 0; m_busy[3] = 0;
    exp_n = 1; exp_m[0] = mk(1, 2, 1, 0, 3);
    run(0, 1, 0, 3, "R8 parity nak");
    check(par_err && err_line == 3'd3, "R8 err flag", {par_err, err_line}, 4'b1011);
    go(0, 1, 0, 3, "R8 entry rewritten uncached");
    go(1, 2, 0, 4, "R4 rdx");
    check(par_err && err_line == 3'd3, "R8 sticky", {par_err, err_line}, 4'b1011);

    for (int k = 0; k < 400; k++) begin
      l = int'($urandom % N_LINES);
      o = owner_of(m_pres[l]);
      if (m_busy[l] && ($urandom % 2) == 0) begin
        if (m_pk[l] == 0) go(2, o, m_preq[l], l, "R3 random sharing writeback");
        else              go(3, o, m_preq[l], l, "R5 random ownership update");
      end else if (m_dirty[l] && !m_busy[l] && ($urandom % 4) == 0) begin
        go(4, o, 0, l, "R6 random dirty writeback");
      end else begin
        t = int'($urandom % 2);
        s = int'($urandom % N_CL);
        go(t, s, 0, l, "R2 R4 R7 random access");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule